// File: doc/BRIEF.md
# CORDIC waveform synthesizer

This block produces a stream of digital waveform samples. A phase counter steps once per sample. Its value selects an angle, and an iterative shift-and-add rotation engine turns that angle into the output sample.

In the circular setting the engine works on an angle folded into the first eighth of the circle. Sign and swap logic then rebuilds cosine and sine over the whole turn. In the hyperbolic setting the phase maps onto a symmetric angle range, and the block returns cosh, sinh and their sum, which is e^z. Counting up gives a rising exponential and counting down gives a falling one.

An optional pseudo-random dither adds a small offset to the phase. Results are 16-bit signed values with 14 fractional bits (Q2.14). Each result is marked by a one-cycle strobe.

Top module: `cdds_synth`

## Requirements
- R1: After reset, sample_valid is low and wave_x, wave_y and wave_exp are zero. The phase counter is 0 and the dither register holds 16'hACE1. Internally, reset is asserted at once and released two clock edges after rst_n rises.
- R2: While en stays high, one sample completes every 17 clock cycles. sample_valid is high for exactly one cycle per sample, and the three outputs change only in the cycle where sample_valid is high.
- R3: The 8-bit phase counter starts each sample with its current value as the sample's phase p. It then moves by +1, or by -1 when count_down is high, wrapping modulo 256. With no dither, the first sample after reset uses p = 0.
- R4: When mode is 0 (circular), wave_x = cos(2πp/256) and wave_y = sin(2πp/256), within 24 LSB, for every p. The top three bits of p give the octant that is folded and then restored.
- R5: When mode is 0, wave_exp is 0.
- R6: When mode is 1 (hyperbolic), the angle is z = (p − 128)/256 rad, so −0.5 ≤ z < 0.5. Then wave_x = cosh z and wave_y = sinh z, within 24 LSB.
- R7: When mode is 1, wave_exp = e^z within 24 LSB. With an upward count from reset the exponential strictly rises over phases 0..255. With a downward count it strictly falls from the second sample onward.
- R8: When dither_en is high, the phase used is the counter plus the two low bits of a 16-bit dither register, modulo 256.
  - The register steps once at every sample start, whatever the value of dither_en.
  - Each step shifts it right by one and, if the bit shifted out was 1, XORs the result with 16'hD008.
- R9: While en is low, no new sample starts and the counter and dither register hold. A sample already in progress still completes, and the outputs keep their last values.
- R10: mode, count_down and dither_en take effect only at a sample start. A change during a running sample does not alter that sample's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows new samples to start |
| mode | input | 1 | 0 = circular (cos/sin), 1 = hyperbolic (cosh/sinh/exp) |
| count_down | input | 1 | 1 = phase counter decrements |
| dither_en | input | 1 | 1 = add pseudo-random low-bit phase offset |
| sample_valid | output | 1 | One-cycle strobe marking a new result |
| wave_x | output | 16 | Q2.14 cosine or cosh |
| wave_y | output | 16 | Q2.14 sine or sinh |
| wave_exp | output | 16 | Q2.14 exponential (zero in circular mode) |

## Verification
The bench walks all 256 phases in both count directions and in both modes. This covers every octant boundary, where a wrong swap or sign rule flips or exchanges cosine and sine. It also covers both ends of the hyperbolic range, where wrong repeated iterations or a wrong gain preload throw the magnitude off.

Monotonicity checks on the exponential catch a counter that runs the wrong way. A dither window switched on mid-run exposes a dither register that only advances while dither is enabled. Toggling en and mode in the middle of a sample shows whether the engine latches its inputs at the start or lets a late change corrupt a result in flight.

// File: rtl/cdds_pkg.sv
package cdds_pkg;

  localparam int DATA_W   = 16;  // output word, Q2.14
  localparam int FRAC_W   = 14;
  localparam int GUARD_W  = 2;   // extra integer and fraction bits inside the engine
  localparam int N_ITER   = 16;
  localparam int PHASE_W  = 8;
  localparam int LFSR_W   = 16;
  localparam int DITHER_W = 2;

  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hD008;  // x^16+x^15+x^13+x^4+1

  // reciprocal gains in Q(FRAC_W+GUARD_W)
  localparam int X0_CIRC = 39797;  // ~0.607253
  localparam int X0_HYP  = 79135;  // ~1.207497

  localparam int QUARTER_PI_Q = 12868;  // pi/4 in Q14

  typedef enum logic {MODE_CIRC = 1'b0, MODE_HYP = 1'b1} wave_mode_e;

  function automatic int unsigned atan_q14(input int unsigned i);
    case (i)
      0: return 12868;  1: return 7596;  2: return 4014;  3: return 2037;
      4: return 1023;   5: return 512;   6: return 256;   7: return 128;
      8: return 64;     9: return 32;    10: return 16;   11: return 8;
      12: return 4;     13: return 2;    14: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned atanh_q14(input int unsigned i);
    case (i)
      1: return 9000;   2: return 4185;  3: return 2059;  4: return 1025;
      5: return 512;    6: return 256;   7: return 128;   8: return 64;
      9: return 32;     10: return 16;   11: return 8;    12: return 4;
      13: return 2;     14: return 1;
      default: return 0;
    endcase
  endfunction

  // hyperbolic shift sequence 1,2,3,4,4,5..13,13,14
  function automatic int unsigned hyp_index(input int unsigned k);
    if (k < 4) return k + 1;
    else if (k < 14) return k;
    else return k - 1;
  endfunction

endpackage

// File: rtl/cdds_phase_gen.sv
module cdds_phase_gen
  import cdds_pkg::*;
#(
  parameter int PW = PHASE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              count_down,
  input  logic              dither_en,
  output logic [PW-1:0]     phase,
  output logic [PW-1:0]     cnt_q,
  output logic [LFSR_W-1:0] lfsr_q
);

  logic [PW-1:0]     cnt_d;
  logic [LFSR_W-1:0] lfsr_d;

  always_comb begin
    cnt_d  = cnt_q;
    lfsr_d = lfsr_q;
    if (step) begin
      cnt_d  = count_down ? cnt_q - 1'b1 : cnt_q + 1'b1;
      lfsr_d = lfsr_q >> 1;
      if (lfsr_q[0]) lfsr_d = lfsr_d ^ LFSR_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lfsr_q <= LFSR_SEED;
    end else begin
      cnt_q  <= cnt_d;
      lfsr_q <= lfsr_d;
    end
  end

  assign phase = cnt_q + (dither_en ? PW'(lfsr_q[DITHER_W-1:0]) : PW'(0));

endmodule

// File: rtl/cdds_angle_lut.sv
module cdds_angle_lut
  import cdds_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int ZW = DATA_W
) (
  input  logic [PW-1:0]        phase,
  output logic [2:0]           octant,
  output logic signed [ZW-1:0] z_circ,
  output logic signed [ZW-1:0] z_hyp
);

  localparam int FB   = PW - 3;
  localparam int NENT = (1 << FB) + 1;
  localparam int STEP = (QUARTER_PI_Q + (1 << (FB - 1))) >> FB;
  localparam int HSH  = FRAC_W - PW;  // z = (p - half) / 2^PW rad

  logic [ZW-1:0]        ang_tab [NENT];
  logic [FB-1:0]        frac;
  logic [FB:0]          idx;
  logic signed [PW-1:0] hv;

  for (genvar i = 0; i < NENT; i++) begin : g_tab
    assign ang_tab[i] = ZW'(i * STEP);
  end

  assign octant = phase[PW-1 -: 3];
  assign frac   = phase[FB-1:0];
  assign idx    = octant[0] ? (FB+1)'(1 << FB) - {1'b0, frac} : {1'b0, frac};
  assign z_circ = signed'(ang_tab[idx]);

  assign hv     = signed'({~phase[PW-1], phase[PW-2:0]});
  assign z_hyp  = ZW'(hv) <<< HSH;

endmodule

// File: rtl/cdds_cordic_iter.sv
module cdds_cordic_iter
  import cdds_pkg::*;
#(
  parameter int IW = DATA_W + 2 * GUARD_W,
  parameter int ZW = DATA_W,
  parameter int NI = N_ITER,
  parameter int TW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 hyp_in,
  input  logic signed [ZW-1:0] z_in,
  input  logic [TW-1:0]        tag_in,
  output logic                 busy_q,
  output logic                 done_q,
  output logic                 hyp_q,
  output logic [TW-1:0]        tag_q,
  output logic signed [IW-1:0] x_q,
  output logic signed [IW-1:0] y_q
);

  localparam int CW = $clog2(NI);

  logic [CW-1:0]        k_q, k_d;
  logic signed [ZW-1:0] z_q, z_d, z_n, ang;
  logic signed [IW-1:0] x_d, y_d, x_n, y_n, xs, ys;
  logic                 busy_d, done_d, hyp_d;
  logic [TW-1:0]        tag_d;
  int unsigned          sh;

  // one rotation step: two shifters, three adders
  always_comb begin
    sh  = hyp_q ? hyp_index(32'(k_q)) : 32'(k_q);
    ang = ZW'(hyp_q ? atanh_q14(sh) : atan_q14(sh));
    xs  = x_q >>> sh;
    ys  = y_q >>> sh;
    if (!z_q[ZW-1]) begin
      x_n = hyp_q ? x_q + ys : x_q - ys;
      y_n = y_q + xs;
      z_n = z_q - ang;
    end else begin
      x_n = hyp_q ? x_q - ys : x_q + ys;
      y_n = y_q - xs;
      z_n = z_q + ang;
    end
  end

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    k_d    = k_q;
    x_d    = x_q;
    y_d    = y_q;
    z_d    = z_q;
    hyp_d  = hyp_q;
    tag_d  = tag_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        k_d    = '0;
        x_d    = hyp_in ? IW'(X0_HYP) : IW'(X0_CIRC);
        y_d    = '0;
        z_d    = z_in;
        hyp_d  = hyp_in;
        tag_d  = tag_in;
      end
    end else begin
      x_d = x_n;
      y_d = y_n;
      z_d = z_n;
      k_d = k_q + 1'b1;
      if (k_q == CW'(NI - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      k_q    <= '0;
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      hyp_q  <= 1'b0;
      tag_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      k_q    <= k_d;
      x_q    <= x_d;
      y_q    <= y_d;
      z_q    <= z_d;
      hyp_q  <= hyp_d;
      tag_q  <= tag_d;
    end
  end

endmodule

// File: rtl/cdds_synth.sv
module cdds_synth
  import cdds_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int DW = DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 mode,
  input  logic                 count_down,
  input  logic                 dither_en,
  output logic                 sample_valid,
  output logic signed [DW-1:0] wave_x,
  output logic signed [DW-1:0] wave_y,
  output logic signed [DW-1:0] wave_exp
);

  localparam int IW = DW + 2 * GUARD_W;

  logic [1:0]           rst_sync_q;
  logic                 rst_core_n;
  wave_mode_e           mode_sel;
  logic                 start, core_busy, core_done, core_hyp;
  logic [PW-1:0]        phase, phase_cnt;
  logic [LFSR_W-1:0]    lfsr_st;
  logic [2:0]           octant, core_oct;
  logic signed [DW-1:0] z_circ, z_hyp;
  logic signed [IW-1:0] core_x, core_y;
  logic signed [DW-1:0] ax, ay, fx, fy, fe;
  logic                 swap;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign mode_sel = wave_mode_e'(mode);
  assign start    = en && !core_busy;

  cdds_phase_gen #(.PW(PW)) u_phase (
    .clk(clk), .rst_n(rst_core_n), .step(start), .count_down(count_down),
    .dither_en(dither_en), .phase(phase), .cnt_q(phase_cnt), .lfsr_q(lfsr_st)
  );

  cdds_angle_lut #(.PW(PW), .ZW(DW)) u_lut (
    .phase(phase), .octant(octant), .z_circ(z_circ), .z_hyp(z_hyp)
  );

  cdds_cordic_iter #(.IW(IW), .ZW(DW), .NI(N_ITER), .TW(3)) u_core (
    .clk(clk), .rst_n(rst_core_n), .start(start),
    .hyp_in(mode_sel == MODE_HYP),
    .z_in((mode_sel == MODE_HYP) ? z_hyp : z_circ),
    .tag_in(octant), .busy_q(core_busy), .done_q(core_done), .hyp_q(core_hyp),
    .tag_q(core_oct), .x_q(core_x), .y_q(core_y)
  );

  // octant restore and output formatting
  always_comb begin
    ax   = DW'(core_x >>> GUARD_W);
    ay   = DW'(core_y >>> GUARD_W);
    swap = core_oct[0] ^ core_oct[1];
    fe   = '0;
    if (core_hyp) begin
      fx = ax;
      fy = ay;
      fe = DW'((core_x + core_y) >>> GUARD_W);
    end else begin
      fx = swap ? ay : ax;
      fy = swap ? ax : ay;
      if (core_oct[2] ^ core_oct[1]) fx = -fx;
      if (core_oct[2])               fy = -fy;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sample_valid <= 1'b0;
      wave_x       <= '0;
      wave_y       <= '0;
      wave_exp     <= '0;
    end else begin
      sample_valid <= core_done;
      if (core_done) begin
        wave_x   <= fx;
        wave_y   <= fy;
        wave_exp <= fe;
      end
    end
  end

endmodule

// File: rtl/cdds_synth_chk.sv
module cdds_synth_chk #(
  parameter int DW = 16,
  parameter int FW = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sample_valid,
  input logic signed [DW-1:0] wave_x,
  input logic signed [DW-1:0] wave_y,
  input logic signed [DW-1:0] wave_exp
);

  localparam longint ONE_SQ = longint'(1) << (2 * FW);
  localparam longint MAG_LO = ONE_SQ - ONE_SQ / 50;
  localparam longint MAG_HI = ONE_SQ + ONE_SQ / 50;
  localparam int     COSH_FLOOR = (1 << FW) - 16;

  logic signed [63:0] mag_sq;
  always_comb mag_sq = 64'(wave_x) * 64'(wave_x) + 64'(wave_y) * 64'(wave_y);

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_outputs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> ($stable(wave_x) && $stable(wave_y) && $stable(wave_exp)));

  // a circular result (exp output zero) lies on the unit circle
  assert_unit_circle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && wave_exp == '0) |-> (mag_sq >= MAG_LO && mag_sq <= MAG_HI));

  assert_cosh_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && wave_exp != '0) |-> (wave_x >= DW'(COSH_FLOOR) && wave_exp > 0));

endmodule

module cdds_phase_chk #(
  parameter int PW = 8,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step,
  input logic          count_down,
  input logic [PW-1:0] cnt_q,
  input logic [LW-1:0] lfsr_q
);

  assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !count_down) |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_down) |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(cnt_q) && $stable(lfsr_q)));

  assert_lfsr_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

bind cdds_synth cdds_synth_chk #(.DW(DW), .FW(cdds_pkg::FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .sample_valid(sample_valid),
  .wave_x(wave_x), .wave_y(wave_y), .wave_exp(wave_exp)
);

bind cdds_phase_gen cdds_phase_chk #(.PW(PW), .LW(cdds_pkg::LFSR_W)) u_phase_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .count_down(count_down),
  .cnt_q(cnt_q), .lfsr_q(lfsr_q)
);

// File: tb/cdds_synth_test.sv
module cdds_synth_test;

  localparam real TWO_PI = 6.283185307179586;
  localparam int  TOL    = 24;

  logic clk = 1'b0;
  logic rst_n, en, mode, count_down, dither_en;
  logic sample_valid;
  logic signed [15:0] wave_x, wave_y, wave_exp;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cdds_synth uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .count_down(count_down),
    .dither_en(dither_en), .sample_valid(sample_valid),
    .wave_x(wave_x), .wave_y(wave_y), .wave_exp(wave_exp)
  );

  function automatic int to_q(input real r);
    return $rtoi(r >= 0.0 ? r * 16384.0 + 0.5 : r * 16384.0 - 0.5);
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    logic [15:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ 16'hD008;
    return n;
  endfunction

  task automatic check_near(input string req, input string what, input int act, input int exp, input int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_true(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic dn, input logic dith);
    rst_n = 1'b0; en = 1'b0; mode = m; count_down = dn; dither_en = dith;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_sample(output int x, output int y, output int e, output int at);
    int g = 0;
    do begin @(negedge clk); g++; end while (!sample_valid && g < 200);
    if (!sample_valid) begin
      failures++;
      $display("FAIL R2 no sample strobe: actual=0 expected=1");
    end
    x = int'(wave_x); y = int'(wave_y); e = int'(wave_exp); at = cyc;
  endtask

  task automatic check_circ(input string req, input int p, input int x, input int y, input int e);
    real th = TWO_PI * real'(p) / 256.0;
    check_near(req, $sformatf("cos p=%0d", p), x, to_q($cos(th)), TOL);
    check_near(req, $sformatf("sin p=%0d", p), y, to_q($sin(th)), TOL);
    check_true("R5", $sformatf("exp zero p=%0d", p), e, 0);
  endtask

  task automatic check_hyp(input string req, input int p, input int x, input int y, input int e);
    real z = real'(p - 128) / 256.0;
    check_near("R6", $sformatf("cosh p=%0d", p), x, to_q($cosh(z)), TOL);
    check_near("R6", $sformatf("sinh p=%0d", p), y, to_q($sinh(z)), TOL);
    check_near(req, $sformatf("exp p=%0d", p), e, to_q($exp(z)), TOL);
  endtask

  // R1: reset state, and nothing starts while en is low
  task automatic test_reset();
    int seen = 0;
    do_reset(1'b0, 1'b0, 1'b0);
    check_true("R1", "sample_valid after reset", int'(sample_valid), 0);
    check_true("R1", "wave_x after reset", int'(wave_x), 0);
    check_true("R1", "wave_y after reset", int'(wave_y), 0);
    check_true("R1", "wave_exp after reset", int'(wave_exp), 0);
    repeat (40) begin @(negedge clk); if (sample_valid) seen++; end
    check_true("R9", "strobes with en low", seen, 0);
  endtask

  // R2 R3 R4 R5: full turn in circular mode
  task automatic test_circular(input logic dn);
    int x, y, e, at, prev = 0;
    do_reset(1'b0, dn, 1'b0);
    en = 1'b1;
    for (int n = 0; n < 256; n++) begin
      wait_sample(x, y, e, at);
      check_circ(dn ? "R3" : "R4", dn ? (256 - n) % 256 : n, x, y, e);
      if (n > 0) check_true("R2", "sample period", at - prev, 17);
      prev = at;
    end
    en = 1'b0;
  endtask

  // R6 R7: hyperbolic sweep, rising or falling exponential
  task automatic test_hyperbolic(input logic dn);
    int x, y, e, at, prev_e = 0;
    do_reset(1'b1, dn, 1'b0);
    en = 1'b1;
    for (int n = 0; n < 256; n++) begin
      wait_sample(x, y, e, at);
      check_hyp("R7", dn ? (256 - n) % 256 : n, x, y, e);
      if (!dn && n >= 1) check_true("R7", $sformatf("rising n=%0d", n), int'(e > prev_e), 1);
      if (dn && n >= 2)  check_true("R7", $sformatf("falling n=%0d", n), int'(e < prev_e), 1);
      prev_e = e;
    end
    en = 1'b0;
  endtask

  // R8: dither from reset, then dither turned on mid-run
  task automatic test_dither();
    int x, y, e, at;
    logic [15:0] s = 16'hACE1;
    do_reset(1'b0, 1'b0, 1'b1);
    en = 1'b1;
    for (int n = 0; n < 64; n++) begin
      wait_sample(x, y, e, at);
      check_circ("R8", (n + int'(s[1:0])) % 256, x, y, e);
      s = lfsr_next(s);
    end
    en = 1'b0;
    do_reset(1'b0, 1'b0, 1'b0);
    s = 16'hACE1;
    en = 1'b1;
    for (int n = 0; n < 40; n++) begin
      wait_sample(x, y, e, at);
      if (n == 9) dither_en = 1'b1;  // sample 10 already started, 11 onward dithered
      if (n >= 10) check_circ("R8", (n + (n >= 11 ? int'(s[1:0]) : 0)) % 256, x, y, e);
      s = lfsr_next(s);
    end
    en = 1'b0;
  endtask

  // R9: en low stops new samples, running one completes, outputs hold
  task automatic test_enable();
    int x, y, e, at, seen = 0, lx = 0, ly = 0;
    do_reset(1'b0, 1'b0, 1'b0);
    en = 1'b1;
    for (int n = 0; n < 5; n++) wait_sample(x, y, e, at);
    en = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (sample_valid) begin seen++; lx = int'(wave_x); ly = int'(wave_y); end
    end
    check_true("R9", "in-flight sample completes", seen, 1);
    check_circ("R9", 5, lx, ly, 0);
    seen = 0;
    repeat (80) begin @(negedge clk); if (sample_valid) seen++; end
    check_true("R9", "no strobe while disabled", seen, 0);
    check_true("R9", "wave_x held", int'(wave_x), lx);
    check_true("R9", "wave_y held", int'(wave_y), ly);
    en = 1'b1;
    wait_sample(x, y, e, at);
    check_circ("R9", 6, x, y, e);
    en = 1'b0;
  endtask

  // R10: mode and direction changed while a sample runs
  task automatic test_midsample();
    int x, y, e, at;
    do_reset(1'b0, 1'b0, 1'b0);
    en = 1'b1;
    wait_sample(x, y, e, at);  // sample 0; sample 1 now running as circular
    mode = 1'b1;
    count_down = 1'b1;
    wait_sample(x, y, e, at);
    check_circ("R10", 1, x, y, e);
    wait_sample(x, y, e, at);
    check_hyp("R10", 2, x, y, e);
    wait_sample(x, y, e, at);
    check_hyp("R10", 1, x, y, e);
    en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; mode = 1'b0; count_down = 1'b0; dither_en = 1'b0;
    fork
      begin
        test_reset();
        test_circular(1'b0);
        test_circular(1'b1);
        test_hyperbolic(1'b0);
        test_hyperbolic(1'b1);
        test_dither();
        test_enable();
        test_midsample();
      end
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule